// File: doc/BRIEF.md
# DSP Address Generation Unit

This block turns an address register into one data-memory address per request and, in the same step, works out the value the register takes next. The caller gives it the current register value, a signed step, the bounds or length of a circular buffer, the FFT size as a bit count, a mode, and a flag that picks pre- or post-modify. The block returns the effective address and the updated register. The caller writes the updated register back and uses it in the next request. Circular wrap-around and bit-reversed stepping happen as part of the register update, so an inner loop needs no extra instructions to check addresses.

Requests enter on a valid/ready handshake, and results leave on a second one. One result register sits between them. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty, or is being emptied in that same cycle by `out_ready`. A result that is not taken stays unchanged, and new requests are held back until it drains. The block accepts one request per cycle as long as the consumer keeps `out_ready` high.

Top module: `dsp_agu`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low and `in_ready` is high until the first request is accepted.
- R2: The result of an accepted request appears on `out_valid`/`out_ea`/`out_areg` one clock after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold their values. `in_ready` equals (not `out_valid`) or `out_ready`.
- R3: With mode code 0 (linear), the updated register is `in_areg + in_step` modulo 2^AW. The step is two's complement, so a negative step decrements and a step of zero gives plain register-indirect addressing.
- R4: With `in_pre` = 1 the effective address equals the updated register. With `in_pre` = 0 it equals the incoming register value. This applies in every mode.
- R5: With mode code 1 (bounded ring), the sum `in_areg + in_step` is compared with the inclusive bounds `in_lo`..`in_hi`. A sum above `in_hi` has the buffer length (`in_hi - in_lo + 1`) subtracted, so stepping by one from the end lands on the start. The result stays in bounds when the register starts in bounds and |step| is at most the length.
- R6: In mode code 1, a sum below `in_lo` has the buffer length added, so a negative step from the start wraps to the end of the buffer.
- R7: With mode code 2 (length ring), the buffer base is the register with its low bits cleared. The low bits are those below the smallest power of two P ≥ `in_len`. The offset (register mod P) plus the step wraps modulo `in_len` in either direction, and the base is kept. `in_len` must be at least 1.
- R8: With mode code 3 (bit-reversed), the low `in_fftlg` bits of register and step are added with the carry running from the most significant bit toward the least. Bits above that field are kept. With `in_fftlg` = 3 and step 4, successive low fields run 0,4,2,6,1,5,3,7. With `in_fftlg` = 0, the register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_areg | input | AW | Current address register value |
| in_step | input | AW | Signed step (two's complement) |
| in_mode | input | 2 | 0 linear, 1 bounded ring, 2 length ring, 3 bit-reversed |
| in_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| in_lo | input | AW | Ring start address (mode 1) |
| in_hi | input | AW | Ring end address, inclusive (mode 1) |
| in_len | input | AW | Ring length (mode 2) |
| in_fftlg | input | LGW | log2 of FFT size (mode 3), clamped to AW |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ea | output | AW | Effective address |
| out_areg | output | AW | Updated address register value |

## Verification
Each result is due exactly one clock after the rising edge that accepts its request, and it stays due until the edge where `out_ready` is high. The bench changes inputs on the falling edge. It reads the outputs and `in_ready` shortly after that edge, when the handshake outcome for the next rising edge is already settled. A behavioural model queues one expected result per accepted request and pops it on the cycle the consumer takes it. Every cycle, `out_valid`, `in_ready` and the head of that queue are compared. Directed register chains drive each wrap and bit-reverse case, and a randomized phase with back-pressure and idle gaps stresses the stall rules.

// File: rtl/dsp_agu_pkg.sv
package dsp_agu_pkg;
  typedef enum logic [1:0] {
    AM_LINEAR  = 2'd0,
    AM_BOUNDED = 2'd1,
    AM_POW2LEN = 2'd2,
    AM_BITREV  = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_ring_bounds.sv
// Circular update between an inclusive start and end address.
module agu_ring_bounds #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 2;

  logic signed [XW-1:0] sum_x;
  logic signed [XW-1:0] lo_x;
  logic signed [XW-1:0] hi_x;
  logic [AW-1:0]        span;
  logic [AW-1:0]        sum_l;

  // widened sum decides the wrap; narrow sum carries the result
  assign sum_x = $signed({2'b00, areg}) + $signed({{2{step[AW-1]}}, step});
  assign lo_x  = $signed({2'b00, lo});
  assign hi_x  = $signed({2'b00, hi});
  assign span  = hi - lo + AW'(1);
  assign sum_l = areg + step;

  always_comb begin
    if (sum_x > hi_x)      nxt = sum_l - span;
    else if (sum_x < lo_x) nxt = sum_l + span;
    else                   nxt = sum_l;
  end
endmodule

// File: rtl/agu_ring_len.sv
// Circular update on a power-of-two aligned base with an arbitrary length.
module agu_ring_len #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 2;

  logic [AW-1:0]        lm1;
  logic [AW-1:0]        msk;
  logic [AW-1:0]        off;
  logic [AW-1:0]        sum_l;
  logic [AW-1:0]        off_n;
  logic signed [XW-1:0] sum_x;
  logic signed [XW-1:0] len_x;

  // smear ones downward: msk = P-1 with P the next power of two >= len
  assign lm1     = len - AW'(1);
  assign msk[AW-1] = lm1[AW-1];
  for (genvar i = AW - 2; i >= 0; i--) begin : g_smear
    assign msk[i] = lm1[i] | msk[i+1];
  end

  assign off   = areg & msk;
  assign sum_x = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
  assign len_x = $signed({2'b00, len});
  assign sum_l = off + step;

  always_comb begin
    if (sum_x >= len_x)               off_n = sum_l - len;
    else if (sum_x < $signed(XW'(0))) off_n = sum_l + len;
    else                              off_n = sum_l;
  end

  assign nxt = (areg & ~msk) | off_n;
endmodule

// File: rtl/agu_revcarry.sv
// Bit-reversed update: carry runs from the top of the low field downward.
module agu_revcarry #(
  parameter int AW  = 16,
  parameter int LGW = 5
) (
  input  logic [AW-1:0]  areg,
  input  logic [AW-1:0]  step,
  input  logic [LGW-1:0] lg,
  output logic [AW-1:0]  nxt
);
  logic [AW-1:0] kmask;
  logic [AW-1:0] a_fl;
  logic [AW-1:0] s_fl;
  logic [AW-1:0] t_fl;
  logic [AW-1:0] a_in;
  logic [AW-1:0] s_in;
  logic [AW-1:0] t_lo;
  logic [AW-1:0] a_r;
  logic [AW-1:0] s_r;
  logic [AW-1:0] t_r;
  int            kk;

  assign a_in = areg & kmask;
  assign s_in = step & kmask;

  // full-width mirrors; the k-bit reversal is the mirror shifted down
  for (genvar i = 0; i < AW; i++) begin : g_flip
    assign a_fl[i] = a_in[AW-1-i];
    assign s_fl[i] = s_in[AW-1-i];
    assign t_fl[i] = t_lo[AW-1-i];
  end

  always_comb begin
    kk    = (int'(lg) > AW) ? AW : int'(lg);
    kmask = (kk >= AW) ? '1 : ((AW'(1) << kk) - AW'(1));
    a_r   = a_fl >> (AW - kk);
    s_r   = s_fl >> (AW - kk);
    t_lo  = (a_r + s_r) & kmask;
    t_r   = t_fl >> (AW - kk);
    nxt   = (areg & ~kmask) | t_r;
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import dsp_agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LGW = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [AW-1:0]  in_areg,
  input  logic [AW-1:0]  in_step,
  input  logic [1:0]     in_mode,
  input  logic           in_pre,
  input  logic [AW-1:0]  in_lo,
  input  logic [AW-1:0]  in_hi,
  input  logic [AW-1:0]  in_len,
  input  logic [LGW-1:0] in_fftlg,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_ea,
  output logic [AW-1:0]  out_areg
);
  agu_mode_e     mode_e;
  logic [AW-1:0] nxt_lin;
  logic [AW-1:0] nxt_bnd;
  logic [AW-1:0] nxt_len;
  logic [AW-1:0] nxt_rev;
  logic [AW-1:0] nxt;
  logic [AW-1:0] ea;
  logic          accept;

  assign mode_e  = agu_mode_e'(in_mode);
  assign nxt_lin = in_areg + in_step;

  agu_ring_bounds #(.AW(AW)) u_bnd (
    .areg(in_areg), .step(in_step), .lo(in_lo), .hi(in_hi), .nxt(nxt_bnd)
  );

  agu_ring_len #(.AW(AW)) u_len (
    .areg(in_areg), .step(in_step), .len(in_len), .nxt(nxt_len)
  );

  agu_revcarry #(.AW(AW), .LGW(LGW)) u_rev (
    .areg(in_areg), .step(in_step), .lg(in_fftlg), .nxt(nxt_rev)
  );

  always_comb begin
    unique case (mode_e)
      AM_BOUNDED: nxt = nxt_bnd;
      AM_POW2LEN: nxt = nxt_len;
      AM_BITREV:  nxt = nxt_rev;
      default:    nxt = nxt_lin;
    endcase
  end

  assign ea = in_pre ? nxt : in_areg;

  // single result register between the two handshakes
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ea    <= '0;
      out_areg  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_ea    <= ea;
      out_areg  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // ---- assertions ----
  logic signed [AW+1:0] chk_span;
  logic signed [AW+1:0] chk_step;
  logic                 chk_bnd_ok;

  assign chk_span   = $signed({2'b00, in_hi}) - $signed({2'b00, in_lo}) + $signed((AW+2)'(1));
  assign chk_step   = $signed({{2{in_step[AW-1]}}, in_step});
  assign chk_bnd_ok = (in_lo <= in_hi) && (in_areg >= in_lo) && (in_areg <= in_hi) &&
                      (chk_step <= chk_span) && (chk_step >= -chk_span);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_areg)); // R2

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_POST_EA: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_pre |=> out_ea == $past(in_areg)); // R4

  AST_PRE_EA: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pre |=> out_ea == out_areg); // R4

  AST_RING_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 2'd1 && chk_bnd_ok
    |=> out_areg >= $past(in_lo) && out_areg <= $past(in_hi)); // R5

  AST_REV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 2'd3
    |=> (out_areg >> $past(in_fftlg)) == ($past(in_areg) >> $past(in_fftlg))); // R8
endmodule

// File: tb/dsp_agu_test.sv
`timescale 1ns/1ps
module dsp_agu_test;
  localparam int AW  = 16;
  localparam int LGW = $clog2(AW + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [AW-1:0]  in_areg = '0;
  logic [AW-1:0]  in_step = '0;
  logic [1:0]     in_mode = '0;
  logic           in_pre = 1'b0;
  logic [AW-1:0]  in_lo = '0;
  logic [AW-1:0]  in_hi = '0;
  logic [AW-1:0]  in_len = '0;
  logic [LGW-1:0] in_fftlg = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [AW-1:0]  out_ea;
  logic [AW-1:0]  out_areg;

  always #5 clk = ~clk;

  dsp_agu #(.AW(AW), .LGW(LGW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_areg(in_areg), .in_step(in_step), .in_mode(in_mode), .in_pre(in_pre),
    .in_lo(in_lo), .in_hi(in_hi), .in_len(in_len), .in_fftlg(in_fftlg),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea), .out_areg(out_areg)
  );

  typedef struct {
    int    ea;
    int    upd;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   bp = 1'b0;
  int   last_upd = 0;
  bit   taken;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int rev(input int x, input int k);
    int r = 0;
    for (int i = 0; i < k; i++) r |= ((x >> i) & 1) << (k - 1 - i);
    return r;
  endfunction

  // behavioural model built from the requirements
  function automatic void model(input int mode, input int pre, input int areg, input int step,
                                input int lo, input int hi, input int len, input int lg,
                                output int ea, output int upd);
    int n = 0;
    case (mode)
      0: n = areg + step;
      1: begin
        int s = areg + step;
        int l = hi - lo + 1;
        if (s > hi) s -= l;
        else if (s < lo) s += l;
        n = s;
      end
      2: begin
        int p = 1;
        int base, off;
        while (p < len) p = p * 2;
        base = areg - (areg % p);
        off  = (areg % p) + step;
        if (off >= len) off -= len;
        else if (off < 0) off += len;
        n = base + off;
      end
      default: begin
        int k = (lg > AW) ? AW : lg;
        int nn = 1 << k;
        int low = areg % nn;
        int r = (rev(low, k) + rev(step & (nn - 1), k)) % nn;
        n = areg - low + rev(r, k);
      end
    endcase
    upd = n & 16'hFFFF;
    ea  = pre ? upd : areg;
  endfunction

  // one cycle: drive at falling edge, then check outputs and handshake
  task automatic tick(input bit v, input int mode, input int pre, input int areg, input int step,
                      input int lo, input int hi, input int len, input int lg, input string tag);
    @(negedge clk);
    in_valid  = v;
    in_mode   = mode[1:0];
    in_pre    = pre[0];
    in_areg   = areg[AW-1:0];
    in_step   = step[AW-1:0];
    in_lo     = lo[AW-1:0];
    in_hi     = hi[AW-1:0];
    in_len    = len[AW-1:0];
    in_fftlg  = lg[LGW-1:0];
    out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
    #1;
    chk("R2", "out_valid", int'(out_valid), int'(q.size() != 0));
    chk("R2", "in_ready", int'(in_ready), int'((q.size() == 0) || out_ready));
    if (out_valid && q.size() != 0) begin
      chk(q[0].tag, "out_ea", int'(out_ea), q[0].ea);
      chk(q[0].tag, "out_areg", int'(out_areg), q[0].upd);
      if (out_ready) void'(q.pop_front());
    end
    taken = 1'b0;
    if (v && in_ready) begin
      exp_t e;
      model(mode, pre, areg, step, lo, hi, len, lg, e.ea, e.upd);
      e.tag = tag;
      q.push_back(e);
      last_upd = e.upd;
      taken = 1'b1;
    end
  endtask

  task automatic send(input int mode, input int pre, input int areg, input int step,
                      input int lo, input int hi, input int len, input int lg, input string tag);
    do tick(1'b1, mode, pre, areg, step, lo, hi, len, lg, tag); while (!taken);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int r;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "in_ready in reset", int'(in_ready), 1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    idle(2);

    // R3: linear post-modify, increment, decrement, indirect, wrap at top
    r = 16'h0100;
    for (int i = 0; i < 4; i++) begin send(0, 0, r, 3, 0, 0, 0, 0, "R3"); r = last_upd; end
    for (int i = 0; i < 3; i++) begin send(0, 0, r, -2, 0, 0, 0, 0, "R3"); r = last_upd; end
    send(0, 0, r, 0, 0, 0, 0, 0, "R3");
    send(0, 0, 16'hFFFF, 1, 0, 0, 0, 0, "R3");
    send(0, 0, 0, -1, 0, 0, 0, 0, "R3");
    idle(1);

    // R4: pre-modify across modes
    r = 16'h0010;
    for (int i = 0; i < 3; i++) begin send(0, 1, r, 5, 0, 0, 0, 0, "R4"); r = last_upd; end
    send(1, 1, 107, 1, 100, 107, 0, 0, "R4");
    send(2, 1, 16'h023F, 1, 0, 0, 10, 0, "R4");
    send(3, 1, 16'h1236, 4, 0, 0, 0, 3, "R4");

    // R5: bounded ring, forward wrap
    r = 104;
    for (int i = 0; i < 10; i++) begin send(1, 0, r, 1, 100, 107, 0, 0, "R5"); r = last_upd; end
    for (int i = 0; i < 6; i++) begin send(1, 0, r, 3, 100, 107, 0, 0, "R5"); r = last_upd; end
    send(1, 0, 107, 8, 100, 107, 0, 0, "R5");

    // R6: bounded ring, backward wrap
    r = 102;
    for (int i = 0; i < 10; i++) begin send(1, 0, r, -1, 100, 107, 0, 0, "R6"); r = last_upd; end
    for (int i = 0; i < 6; i++) begin send(1, 0, r, -3, 100, 107, 0, 0, "R6"); r = last_upd; end

    // R7: length ring on aligned base, both directions, exact power of two
    r = 16'h0235;
    for (int i = 0; i < 12; i++) begin send(2, 0, r, 1, 0, 0, 10, 0, "R7"); r = last_upd; end
    for (int i = 0; i < 6; i++) begin send(2, 0, r, -4, 0, 0, 10, 0, "R7"); r = last_upd; end
    r = 16'h4403;
    for (int i = 0; i < 5; i++) begin send(2, 0, r, 5, 0, 0, 16, 0, "R7"); r = last_upd; end
    send(2, 0, 16'h0777, -1, 0, 0, 1, 0, "R7");

    // R8: bit-reversed 8-point walk; literal order of the low field checked too
    r = 16'h1230;
    for (int i = 0; i < 9; i++) begin
      int ord[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      chk("R8", "8-point order", r & 7, ord[i % 8]);
      send(3, 0, r, 4, 0, 0, 0, 3, "R8");
      r = last_upd;
    end
    r = 16'hABC0;
    for (int i = 0; i < 17; i++) begin send(3, 0, r, 8, 0, 0, 0, 4, "R8"); r = last_upd; end
    send(3, 0, 16'h5A5A, 16'h1234, 0, 0, 0, 0, "R8");
    send(3, 0, 16'h5A5A, 16'h0001, 0, 0, 0, 16, "R8");
    idle(2);

    // randomized phase with back-pressure and gaps
    bp = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int m = $urandom % 4;
      int pre = $urandom % 2;
      int ar = 0, st = 0, lo = 0, hi = 0, ln = 0, lg = 0;
      string tg;
      case (m)
        0: begin ar = $urandom & 16'hFFFF; st = int'($urandom % 64) - 32; tg = "R3"; end
        1: begin
          int l = 1 + $urandom % 40;
          lo = $urandom % (65536 - l);
          hi = lo + l - 1;
          ar = lo + $urandom % l;
          st = int'($urandom % (2 * l + 1)) - l;
          tg = (st < 0) ? "R6" : "R5";
        end
        2: begin
          int p = 1;
          ln = 1 + $urandom % 50;
          while (p < ln) p = p * 2;
          ar = (($urandom & 16'hFFFF) & ~(p - 1)) + $urandom % ln;
          st = int'($urandom % (2 * ln + 1)) - ln;
          tg = "R7";
        end
        default: begin
          lg = $urandom % 11;
          ar = $urandom & 16'hFFFF;
          st = $urandom & 16'hFFFF;
          tg = "R8";
        end
      endcase
      if (pre != 0) tg = "R4";
      send(m, pre, ar, st, lo, hi, ln, lg, tg);
      if ($urandom % 5 == 0) idle(1 + $urandom % 2);
    end
    bp = 1'b0;
    idle(4);
    chk("R2", "drained", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule